// File: doc/BRIEF.md
# Three-Source Interrupt Controller

This block gathers interrupt events for a small 8-bit processor core from three places: an external interrupt pin, a one-cycle overflow pulse from a timer, and any change on a four-bit slice of an input port. Each event is latched into a sticky flag bit of one 8-bit control register. The same register holds a per-source enable for each flag, a global enable, and the edge polarity of the external pin. The control unit reads and writes the register through a simple strobe port.

While the global enable is set and any flag is set together with its own enable, the block raises a request. When the control unit takes the interrupt it pulses an acknowledge. The block then drops the global enable and shows a fixed vector address. A return strobe sets the global enable again. Flags are never cleared by hardware, so the service routine must clear them by a register write. The port-change source compares the synchronized nibble with a snapshot. That snapshot is taken each time software reads the port, so reading the port re-arms the source.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 and the request output is low.
- R2: Register layout: bit 7 global enable, bit 6 edge select for the external pin (1 = rising, 0 = falling), bit 5 external enable, bit 4 timer enable, bit 3 port-change enable, bit 2 external flag, bit 1 timer flag, bit 0 port-change flag. A write strobe loads all eight bits, and the read data shows them every cycle.
- R3: A timer overflow pulse sets bit 1 in the next cycle, whatever the enable bits hold.
- R4: With bit 6 = 1, a rising edge on the external pin sets bit 2 on the third clock edge after the pin changes (two synchronizer stages plus detection). A falling edge does not set it.
- R5: With bit 6 = 0, a falling edge on the external pin sets bit 2 with the same latency. A rising edge does not set it.
- R6: Bit 0 is set while the synchronized port nibble differs from the snapshot. A port read strobe loads the current synchronized nibble into the snapshot, and the snapshot resets to 0.
- R7: The request output is high exactly when bit 7 is set and at least one of the three flags is set together with its own enable.
- R8: An acknowledge clears bit 7 in the next cycle and leaves every flag unchanged.
- R9: A return strobe without an acknowledge sets bit 7 in the next cycle.
- R10: The vector output is always the fixed address 0x0004.
- R11: A hardware flag set in the same cycle as a register write that clears that flag wins, so the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| tmr_ovf | input | 1 | Timer overflow pulse, one cycle |
| port_hi | input | 4 | Upper port nibble, asynchronous |
| port_rd | input | 1 | Strobe marking a software read of the port |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| irq_ack | input | 1 | Interrupt accepted by the control unit |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 16 | Fixed interrupt vector address |

## Verification
The bench checks the exact external-pin latency and probes one edge early. A design with one synchronizer stage too few or too many would set the flag a cycle off. Each polarity setting also gets the opposite edge, which must leave the flag clear. The port-change test re-arms the snapshot with a read and then clears the flag. A design that compared against the previous sample, or never updated the snapshot, would either miss the change or set the flag again. The bench also checks the acknowledge/return sequence, a flagged source whose enable is off, and a timer pulse that lands in the same cycle as a clearing write. A design that let software win that collision would lose the event.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VECTOR = 16'h0004,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             tmr_ovf,
  input  logic [NIB_W-1:0] port_hi,
  input  logic             port_rd,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector
);
  logic gie, edge_rise;
  logic [2:0] en, flg;
  logic [2:0] ext_s;
  logic [NIB_W-1:0] nib_s1, nib_s2, nib_snap;
  logic ext_evt, chg_evt;
  logic [2:0] set_evt, flg_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_s    <= '0;
      nib_s1   <= '0;
      nib_s2   <= '0;
      nib_snap <= '0;
    end else begin
      ext_s  <= {ext_s[1:0], ext_pin};
      nib_s1 <= port_hi;
      nib_s2 <= nib_s1;
      if (port_rd) nib_snap <= nib_s2;
    end
  end

  assign ext_evt = edge_rise ? (ext_s[1] & ~ext_s[2]) : (~ext_s[1] & ext_s[2]);
  assign chg_evt = (nib_s2 != nib_snap);
  assign set_evt = {ext_evt, tmr_ovf, chg_evt};
  assign flg_base = reg_wr ? reg_wdata[2:0] : flg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie       <= 1'b0;
      edge_rise <= 1'b0;
      en        <= '0;
      flg       <= '0;
    end else begin
      if (reg_wr) begin
        edge_rise <= reg_wdata[6];
        en        <= reg_wdata[5:3];
      end
      flg <= flg_base | set_evt;
      if (irq_ack)      gie <= 1'b0;
      else if (irq_ret) gie <= 1'b1;
      else if (reg_wr)  gie <= reg_wdata[7];
    end
  end

  assign reg_rdata  = {gie, edge_rise, en, flg};
  assign irq_req    = gie & |(en & flg);
  assign irq_vector = VECTOR;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_ovf,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       irq_req
);
  p_ack_clears_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !reg_rdata[7]);
  p_ret_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack) |=> reg_rdata[7]);
  p_req_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> reg_rdata[7]);
  p_tmr_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> reg_rdata[1]);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] && !reg_wr) |=> reg_rdata[1]);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic ext_pin = 0, tmr_ovf = 0, port_rd = 0, reg_wr = 0, irq_ack = 0, irq_ret = 0;
  logic [3:0] port_hi = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq_req;
  logic [15:0] irq_vector;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_ctrl dut (.clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .port_hi(port_hi), .port_rd(port_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
    .irq_vector(irq_vector));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 reg", reg_rdata, 8'h00);
    chk("R1 req", irq_req, 0);
    chk("R10 vector", irq_vector, 16'h0004);
  endtask

  task automatic t_readback;
    wr(8'h7A);
    chk("R2 readback", reg_rdata, 8'h7A);
    wr(8'h00);
    chk("R2 clear", reg_rdata, 8'h00);
  endtask

  task automatic t_timer;
    tmr_ovf = 1; @(negedge clk); tmr_ovf = 0;
    chk("R3 flag without enable", reg_rdata, 8'h02);
    tmr_ovf = 1; reg_wr = 1; reg_wdata = 8'h00;
    @(negedge clk);
    tmr_ovf = 0; reg_wr = 0;
    chk("R11 set beats clear", reg_rdata[1], 1);
    wr(8'h00);
  endtask

  task automatic t_ext_rise;
    wr(8'h40);
    ext_pin = 1;
    wait_n(2);
    chk("R4 not yet", reg_rdata[2], 0);
    wait_n(1);
    chk("R4 rising latency", reg_rdata[2], 1);
    wr(8'h40);
    ext_pin = 0;
    wait_n(4);
    chk("R4 falling ignored", reg_rdata[2], 0);
  endtask

  task automatic t_ext_fall;
    wr(8'h00);
    ext_pin = 1;
    wait_n(4);
    chk("R5 rising ignored", reg_rdata[2], 0);
    ext_pin = 0;
    wait_n(3);
    chk("R5 falling latency", reg_rdata[2], 1);
    wr(8'h00);
  endtask

  task automatic t_port;
    port_hi = 4'hA;
    wait_n(4);
    chk("R6 change flag", reg_rdata[0], 1);
    port_rd = 1; @(negedge clk); port_rd = 0;
    wr(8'h00);
    wait_n(3);
    chk("R6 snapshot rearmed", reg_rdata[0], 0);
    port_hi = 4'hB;
    wait_n(4);
    chk("R6 new change", reg_rdata[0], 1);
    port_rd = 1; @(negedge clk); port_rd = 0;
    wr(8'h00);
  endtask

  task automatic t_req_cycle;
    wr(8'h82);
    chk("R7 flag not enabled", irq_req, 0);
    wr(8'h90);
    chk("R7 no flag", irq_req, 0);
    tmr_ovf = 1; @(negedge clk); tmr_ovf = 0;
    chk("R7 request", irq_req, 1);
    chk("R10 vector", irq_vector, 16'h0004);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R8 ack state", reg_rdata, 8'h12);
    chk("R8 req dropped", irq_req, 0);
    irq_ret = 1; @(negedge clk); irq_ret = 0;
    chk("R9 ret state", reg_rdata, 8'h92);
    chk("R9 req again", irq_req, 1);
    wr(8'h00);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_timer();
    t_ext_rise();
    t_ext_fall();
    t_port();
    t_req_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule